// File: doc/BRIEF.md
# Two-Port Shared Mailbox with Wake Flags

The block is a point-to-point message channel between two processors. Each processor owns one port. A port has a single-cycle request interface that carries an enable, a write strobe, an address and write data. Through its port, each side reaches a shared true dual-port word store and two one-bit synchronisation flags. Both of these sit in the same address window, and that window has the same layout on both ports. The producer fills words in the store and then writes to a flag. The consumer reads the words and then clears the flag.

There are two flags. Flag 0 carries events from port A to port B, and flag 1 carries events from port B to port A, so traffic can flow both ways. A flag is sticky and does not count. Writing any non-zero value sets it to 1 and writing zero clears it to 0. If a set and a clear hit the same flag in the same cycle, the set wins. Each side has a wait output that stays high while the flag it listens to is clear. The wait output can stall a sleeping processor, so the processor does not need to poll.

Top module: `shared_mailbox`

## Requirements
- R1: A word written to the store through either port is returned by a later read of the same word through either port.
- R2: A read issued in cycle N presents its data on that port's rdata from cycle N+1. rdata holds its value in cycles when that port issues no read, and that includes its own write cycles.
- R3: When one port reads a word that the other port writes in the same cycle, the read returns the old content, and the new content is stored.
- R4: When both ports write the same word in the same cycle, port A's data is stored.
- R5: Address decoding works as follows. If the address MSB is 0, bits [RAM_AW-1:0] select a store word. If the MSB is 1, address bit 0 selects the flag, with 0 meaning flag 0 (A-to-B) and 1 meaning flag 1 (B-to-A). Every other address bit is ignored in the flag region.
- R6: A flag write with non-zero data sets the flag, and a flag write with zero data clears it. A flag reads back as its value in bit 0, with all upper rdata bits zero.
- R7: Repeated sets before a clear are not counted: a single clear after several sets leaves the flag at 0.
- R8: When one port sets a flag and the other port clears the same flag in the same cycle, the flag ends up set.
- R9: b_wait is high exactly while flag 0 is clear, and a_wait is high exactly while flag 1 is clear. A wait output drops in the cycle after the clock edge that takes the set write.
- R10: After reset both flags are clear, both wait outputs are high and both rdata outputs are zero.
- R11: Flag writes leave the store contents unchanged, and store writes leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_en | input | 1 | Port A access request |
| a_we | input | 1 | Port A write strobe (0 = read) |
| a_addr | input | RAM_AW+1 | Port A address within its window |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, one cycle after the read |
| a_wait | output | 1 | High while flag 1 (B-to-A) is clear |
| b_en | input | 1 | Port B access request |
| b_we | input | 1 | Port B write strobe (0 = read) |
| b_addr | input | RAM_AW+1 | Port B address within its window |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, one cycle after the read |
| b_wait | output | 1 | High while flag 0 (A-to-B) is clear |

## Verification
The bench builds the block with DW=16 and RAM_AW=3. This gives an 8-word store and a 4-bit window, so the first and last store words and several aliased flag addresses are all reachable with directed accesses. The narrow data width lets a write value with only upper bits set, such as 0x0100, test that any non-zero write sets a flag. With two ports driven together, the bench can stage every same-cycle collision: a read against a write, a write against a write, and a set against a clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned NUM_FLAGS = 2;

  typedef enum logic {
    RD_SRC_RAM  = 1'b0,
    RD_SRC_FLAG = 1'b1
  } rd_src_e;

  // Region of the window: MSB high selects the flag region.
  function automatic logic in_flag_region(input logic addr_msb);
    return addr_msb;
  endfunction

  // A flag write sets on any non-zero data, clears on zero.
  function automatic logic data_sets_flag(input logic [63:0] wdata_ext);
    return |wdata_ext;
  endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned RAM_AW = 4
) (
  input  logic                 acc_en,
  input  logic                 acc_we,
  input  logic [RAM_AW:0]      acc_addr,
  input  logic [DW-1:0]        acc_wdata,
  output logic                 ram_rd,
  output logic                 ram_wr,
  output logic [RAM_AW-1:0]    ram_addr,
  output logic                 flag_rd,
  output logic                 flag_idx,
  output logic [NUM_FLAGS-1:0] flag_set,
  output logic [NUM_FLAGS-1:0] flag_clr
);

  localparam int unsigned AW = RAM_AW + 1;

  logic hit_flag;
  logic wr_nonzero;
  logic flag_wr;

  assign hit_flag   = in_flag_region(acc_addr[AW-1]);
  assign wr_nonzero = data_sets_flag(64'(acc_wdata));
  assign flag_idx   = acc_addr[0];
  assign ram_addr   = acc_addr[RAM_AW-1:0];

  assign ram_rd  = acc_en & ~acc_we & ~hit_flag;
  assign ram_wr  = acc_en &  acc_we & ~hit_flag;
  assign flag_rd = acc_en & ~acc_we &  hit_flag;
  assign flag_wr = acc_en &  acc_we &  hit_flag;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_fsel
    logic picked;
    assign picked      = flag_wr & (flag_idx == 1'(f));
    assign flag_set[f] = picked &  wr_nonzero;
    assign flag_clr[f] = picked & ~wr_nonzero;
  end

endmodule

// File: rtl/mbx_dpram.sv
module mbx_dpram #(
  parameter int unsigned DW     = 32,
  parameter int unsigned RAM_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rd,
  input  logic              a_wr,
  input  logic [RAM_AW-1:0] a_addr,
  input  logic [DW-1:0]     a_wdata,
  output logic [DW-1:0]     a_q,
  input  logic              b_rd,
  input  logic              b_wr,
  input  logic [RAM_AW-1:0] b_addr,
  input  logic [DW-1:0]     b_wdata,
  output logic [DW-1:0]     b_q
);

  localparam int unsigned DEPTH = 1 << RAM_AW;

  logic [DW-1:0] mem [DEPTH];
  logic          collide;
  logic          b_wr_eff;

  // Port A owns a word both ports write in one cycle.
  assign collide  = a_wr & b_wr & (a_addr == b_addr);
  assign b_wr_eff = b_wr & ~collide;

  always_ff @(posedge clk) begin
    if (b_wr_eff) mem[b_addr] <= b_wdata;
    if (a_wr)     mem[a_addr] <= a_wdata;
  end

  // Read-first: nonblocking read takes the pre-write contents.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_rd) a_q <= mem[a_addr];
      if (b_rd) b_q <= mem[b_addr];
    end
  end

  p_port_a_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> mem[$past(a_addr)] == $past(a_wdata));

  p_b_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_eff |=> mem[$past(b_addr)] == $past(b_wdata));

endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_req,
  input  logic [NSRC-1:0] clr_req,
  output logic            state
);

  logic any_set;
  logic any_clr;

  assign any_set = |set_req;
  assign any_clr = |clr_req;

  // Sticky, non-counting; a set beats a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= 1'b0;
    else if (any_set) state <= 1'b1;
    else if (any_clr) state <= 1'b0;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_set |=> state);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_clr && !any_set) |=> !state);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_set && !any_clr) |=> $stable(state));

endmodule

// File: rtl/shared_mailbox.sv
module shared_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned RAM_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [RAM_AW:0]   a_addr,
  input  logic [DW-1:0]     a_wdata,
  output logic [DW-1:0]     a_rdata,
  output logic              a_wait,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [RAM_AW:0]   b_addr,
  input  logic [DW-1:0]     b_wdata,
  output logic [DW-1:0]     b_rdata,
  output logic              b_wait
);

  localparam int unsigned AW = RAM_AW + 1;

  logic                 p_en    [NUM_PORTS];
  logic                 p_we    [NUM_PORTS];
  logic [AW-1:0]        p_addr  [NUM_PORTS];
  logic [DW-1:0]        p_wdata [NUM_PORTS];
  logic [DW-1:0]        p_rdata [NUM_PORTS];

  logic                 ram_rd   [NUM_PORTS];
  logic                 ram_wr   [NUM_PORTS];
  logic [RAM_AW-1:0]    ram_addr [NUM_PORTS];
  logic [DW-1:0]        ram_q    [NUM_PORTS];
  logic                 flag_rd  [NUM_PORTS];
  logic                 flag_idx [NUM_PORTS];
  logic [NUM_FLAGS-1:0] set_mat  [NUM_PORTS];
  logic [NUM_FLAGS-1:0] clr_mat  [NUM_PORTS];
  logic [NUM_FLAGS-1:0] flag_state;

  assign p_en[0]    = a_en;
  assign p_we[0]    = a_we;
  assign p_addr[0]  = a_addr;
  assign p_wdata[0] = a_wdata;
  assign p_en[1]    = b_en;
  assign p_we[1]    = b_we;
  assign p_addr[1]  = b_addr;
  assign p_wdata[1] = b_wdata;
  assign a_rdata    = p_rdata[0];
  assign b_rdata    = p_rdata[1];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    rd_src_e src_q;
    logic    fbit_q;

    mbx_port_dec #(.DW(DW), .RAM_AW(RAM_AW)) i_dec (
      .acc_en   (p_en[p]),
      .acc_we   (p_we[p]),
      .acc_addr (p_addr[p]),
      .acc_wdata(p_wdata[p]),
      .ram_rd   (ram_rd[p]),
      .ram_wr   (ram_wr[p]),
      .ram_addr (ram_addr[p]),
      .flag_rd  (flag_rd[p]),
      .flag_idx (flag_idx[p]),
      .flag_set (set_mat[p]),
      .flag_clr (clr_mat[p])
    );

    // Remember which source the last read came from; hold otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q  <= RD_SRC_RAM;
        fbit_q <= 1'b0;
      end else if (flag_rd[p]) begin
        src_q  <= RD_SRC_FLAG;
        fbit_q <= flag_state[flag_idx[p]];
      end else if (ram_rd[p]) begin
        src_q  <= RD_SRC_RAM;
      end
    end

    assign p_rdata[p] = (src_q == RD_SRC_FLAG) ? DW'(fbit_q) : ram_q[p];
  end

  mbx_dpram #(.DW(DW), .RAM_AW(RAM_AW)) i_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_rd   (ram_rd[0]),
    .a_wr   (ram_wr[0]),
    .a_addr (ram_addr[0]),
    .a_wdata(p_wdata[0]),
    .a_q    (ram_q[0]),
    .b_rd   (ram_rd[1]),
    .b_wr   (ram_wr[1]),
    .b_addr (ram_addr[1]),
    .b_wdata(p_wdata[1]),
    .b_q    (ram_q[1])
  );

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    logic [NUM_PORTS-1:0] set_v;
    logic [NUM_PORTS-1:0] clr_v;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_src
      assign set_v[p] = set_mat[p][f];
      assign clr_v[p] = clr_mat[p][f];
    end
    mbx_flag_cell #(.NSRC(NUM_PORTS)) i_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_req(set_v),
      .clr_req(clr_v),
      .state  (flag_state[f])
    );
  end

  // Flag 0 wakes port B, flag 1 wakes port A.
  assign b_wait = ~flag_state[0];
  assign a_wait = ~flag_state[1];

  p_wake_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && a_addr[AW-1] && !a_addr[0] && (a_wdata != '0)) |=> !b_wait);

  p_wake_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_we && b_addr[AW-1] && b_addr[0] && (b_wdata != '0)) |=> !a_wait);

  p_flag_read_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !a_we && a_addr[AW-1]) |=> (a_rdata >> 1) == '0);

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_en && !b_we) |=> $stable(b_rdata));

endmodule

// File: tb/test_shared_mailbox.sv
module test_shared_mailbox;

  localparam int unsigned DW     = 16;
  localparam int unsigned RAM_AW = 3;
  localparam int unsigned AW     = RAM_AW + 1;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG_CYCLES = 5000;

  localparam logic [AW-1:0] FLAG0     = 4'b1000;
  localparam logic [AW-1:0] FLAG1     = 4'b1001;
  localparam logic [AW-1:0] FLAG0_ALI = 4'b1110;
  localparam logic [AW-1:0] FLAG1_ALI = 4'b1111;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic          a_wait, b_wait;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_mailbox #(.DW(DW), .RAM_AW(RAM_AW)) i_shared_mailbox (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_wait(a_wait),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_wait(b_wait)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  // One clock with both ports driven; returns at the following negedge.
  task automatic cyc(input logic ae, input logic awe, input logic [AW-1:0] aa,
                     input logic [DW-1:0] ad,
                     input logic be, input logic bwe, input logic [AW-1:0] ba,
                     input logic [DW-1:0] bd);
    a_en = ae; a_we = awe; a_addr = aa; a_wdata = ad;
    b_en = be; b_we = bwe; b_addr = ba; b_wdata = bd;
    @(negedge clk);
    a_en = 1'b0; a_we = 1'b0; b_en = 1'b0; b_we = 1'b0;
  endtask

  task automatic a_wr(input logic [AW-1:0] ad, input logic [DW-1:0] d);
    cyc(1, 1, ad, d, 0, 0, '0, '0);
  endtask
  task automatic b_wr(input logic [AW-1:0] ad, input logic [DW-1:0] d);
    cyc(0, 0, '0, '0, 1, 1, ad, d);
  endtask
  task automatic a_rd(input logic [AW-1:0] ad);
    cyc(1, 0, ad, '0, 0, 0, '0, '0);
  endtask
  task automatic b_rd(input logic [AW-1:0] ad);
    cyc(0, 0, '0, '0, 1, 0, ad, '0);
  endtask
  task automatic idle();
    cyc(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic t_reset_r10();
    check("R10", "a_rdata after reset", 32'(a_rdata), 0);
    check("R10", "b_rdata after reset", 32'(b_rdata), 0);
    check("R10", "a_wait after reset", 32'(a_wait), 1);
    check("R10", "b_wait after reset", 32'(b_wait), 1);
  endtask

  task automatic t_cross_r1();
    a_wr(4'd2, 16'h1234);
    b_rd(4'd2);
    check("R1", "B reads A's word 2", 32'(b_rdata), 32'h1234);
    b_wr(4'd7, 16'hBEEF);
    a_rd(4'd7);
    check("R1", "A reads B's last word", 32'(a_rdata), 32'hBEEF);
    a_wr(4'd0, 16'h0F0F);
    a_rd(4'd0);
    check("R1", "A reads own word 0", 32'(a_rdata), 32'h0F0F);
  endtask

  task automatic t_latency_r2();
    a_en = 1'b1; a_we = 1'b0; a_addr = 4'd2;
    @(posedge clk); #1;
    a_en = 1'b0;
    check("R2", "data right after the read edge", 32'(a_rdata), 32'h1234);
    @(negedge clk);
    idle();
    check("R2", "rdata held while idle", 32'(a_rdata), 32'h1234);
    a_wr(4'd3, 16'h7777);
    check("R2", "rdata held over own write", 32'(a_rdata), 32'h1234);
  endtask

  task automatic t_read_first_r3();
    cyc(1, 1, 4'd2, 16'h5555, 1, 0, 4'd2, '0);
    check("R3", "B read during A write gets old", 32'(b_rdata), 32'h1234);
    b_rd(4'd2);
    check("R3", "new data stored", 32'(b_rdata), 32'h5555);
  endtask

  task automatic t_collide_r4();
    cyc(1, 1, 4'd5, 16'hAAAA, 1, 1, 4'd5, 16'hBBBB);
    b_rd(4'd5);
    check("R4", "A wins same-word write", 32'(b_rdata), 32'hAAAA);
  endtask

  task automatic t_flag_set_r9();
    check("R9", "b_wait before set", 32'(b_wait), 1);
    a_en = 1'b1; a_we = 1'b1; a_addr = FLAG0; a_wdata = 16'h0100;
    @(posedge clk); #1;
    a_en = 1'b0; a_we = 1'b0;
    check("R9", "b_wait after set edge", 32'(b_wait), 0);
    check("R9", "a_wait unaffected by flag 0", 32'(a_wait), 1);
    @(negedge clk);
    b_rd(FLAG0_ALI);
    check("R5", "aliased flag 0 address reads set", 32'(b_rdata), 1);
    check("R6", "upper-bit-only data set flag 0", 32'(b_rdata), 1);
    a_rd(FLAG1_ALI);
    check("R5", "aliased flag 1 reads clear", 32'(a_rdata), 0);
  endtask

  task automatic t_sticky_r7();
    b_wr(FLAG1, 16'h0001);
    b_wr(FLAG1, 16'h0002);
    b_wr(FLAG1, 16'hFFFF);
    check("R9", "a_wait low with flag 1 set", 32'(a_wait), 0);
    a_rd(FLAG1);
    check("R6", "flag reads 1, upper bits zero", 32'(a_rdata), 1);
    a_wr(FLAG1, 16'h0000);
    a_rd(FLAG1);
    check("R7", "one clear after three sets", 32'(a_rdata), 0);
    check("R9", "a_wait back high", 32'(a_wait), 1);
  endtask

  task automatic t_set_wins_r8();
    b_wr(FLAG0, 16'h0000);
    check("R6", "zero write cleared flag 0", 32'(b_wait), 1);
    cyc(1, 1, FLAG0, 16'h0004, 1, 1, FLAG0, 16'h0000);
    b_rd(FLAG0);
    check("R8", "set beats clear", 32'(b_rdata), 1);
    check("R8", "b_wait low after race", 32'(b_wait), 0);
  endtask

  task automatic t_isolation_r11();
    a_rd(4'd2);
    check("R11", "word 2 intact after flag writes", 32'(a_rdata), 32'h5555);
    a_wr(4'd0, 16'h0000);
    b_wr(4'd1, 16'h0001);
    b_rd(FLAG0);
    check("R11", "flag 0 intact after store writes", 32'(b_rdata), 1);
    a_rd(FLAG1);
    check("R11", "flag 1 intact after store writes", 32'(a_rdata), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r10();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r10();
    t_cross_r1();
    t_latency_r2();
    t_read_first_r3();
    t_collide_r4();
    t_flag_set_r9();
    t_sticky_r7();
    t_set_wins_r8();
    t_isolation_r11();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule